// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small byte-wide datapath. Each cycle in which `in_valid` is high, it takes a destination byte, a source byte, a carry input and a four-bit operation code. It computes the result combinationally and registers it. One cycle later the result appears on `out_result`, with `out_valid` and a write-enable that tells the register file whether to store it.

Five status bits (zero, carry, sign, overflow, parity) sit in a flag register. Their update rule depends on the operation class. Additive operations derive carry and overflow from the adder. Bitwise operations force carry and overflow low. Inversion leaves all five bits alone. Compare and test produce flags but never assert the write-enable. Codes 11 to 15 are unassigned and act as no-ops.

Top module: `byte_flag_alu`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `out_result` holds the operation's byte. The codes and results are:
  - 0: dst+src
  - 1: dst+src+carry_in
  - 2: dst-src
  - 3: dst-src-carry_in
  - 4: compare (result dst-src)
  - 5: dst AND src
  - 6: dst OR src
  - 7: dst XOR src
  - 8: test (result dst AND src)
  - 9: NOT dst
  - 10: 0-dst
- R2: After any flag-updating operation, `flag_zero` is 1 exactly when the 8-bit result is 00h.
- R3: After any flag-updating operation, `flag_sign` equals result bit 7.
- R4: After any flag-updating operation, `flag_parity` is 1 when the low byte of the result has an even number of ones, and 0 when the count is odd.
- R5: Codes 5 to 8 (the bitwise operations) clear `flag_carry` and `flag_ovf`.
- R6: Code 9 inverts every bit of dst and leaves all five flags unchanged.
- R7: For codes 0 and 1, `flag_carry` is the unsigned carry out of bit 7. `flag_ovf` is set when both operands have the same sign and the result's sign differs from it. Examples: 7Fh+01h sets overflow; FFh+FFh gives FEh with carry set.
- R8: For codes 2, 3, 4 and 10, `flag_carry` is the borrow: the unsigned subtrahend plus borrow-in exceeds the minuend. `flag_ovf` is set when the operand signs differ and the result's sign differs from the minuend's sign. Code 10 uses minuend 0 and subtrahend dst. Examples:
  - 80h-01h sets overflow.
  - Negating 80h gives 80h with overflow set.
  - Negating 7Fh gives 81h with overflow clear.
  - Comparing 5 with 10 sets carry.
- R9: Codes 4 and 8 update the flags but give `out_wr_en` = 0. All other defined codes give `out_wr_en` = 1.
- R10: With `in_valid` low, or with an unassigned code 11 to 15, the flags do not change and `out_wr_en` is 0. With `in_valid` low, `out_valid` is also 0.
- R11: After reset, `out_valid`, `out_wr_en`, `out_result` and all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 4 | Operation code (see R1) |
| in_dst | input | 8 | Destination / first operand |
| in_src | input | 8 | Source / second operand |
| in_carry | input | 1 | Carry or borrow input for codes 1 and 3 |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 8 | Registered result byte |
| out_wr_en | output | 1 | Result should be written back |
| flag_zero | output | 1 | Zero flag |
| flag_carry | output | 1 | Carry / borrow flag |
| flag_sign | output | 1 | Sign flag |
| flag_ovf | output | 1 | Signed overflow flag |
| flag_parity | output | 1 | Even parity of the low result byte |

## Verification
The assertions assume that `in_op` and the operands are stable, known values whenever `in_valid` is high. The result-to-flag checks also assume that the registered result and the flag register are loaded on the same strobe. The stimulus therefore changes every input only on the falling clock edge and never leaves `in_op` unknown. It sweeps all eleven defined codes over a strided grid of operand pairs with both carry-in values. It also exercises every unassigned code and idle cycles, so the hold and no-write paths are covered as well.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_TEST = 4'd8,
    OP_NOT  = 4'd9,
    OP_NEG  = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_INV = 2'd3
  } logic_sel_e;

  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic parity;
    logic carry;
  } alu_flags_t;

  // even number of ones in a byte -> 1
  function automatic logic even_ones(input logic [7:0] v);
    return ~(^v);
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         do_sub,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic         c_out;

  // subtraction is a + ~b + ~borrow_in; carry-out low means a borrow
  always_comb begin
    b_eff        = do_sub ? ~b : b;
    c_eff        = do_sub ? ~cin : cin;
    {c_out, res} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    carry        = do_sub ? ~c_out : c_out;
    ovf          = (a[MSB] == b_eff[MSB]) && (res[MSB] != a[MSB]);
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_sel_e   sel,
  output logic [W-1:0] res
);

  always_comb begin
    unique case (sel)
      LG_AND:  res = a & b;
      LG_OR:   res = a | b;
      LG_XOR:  res = a ^ b;
      default: res = ~a;
    endcase
  end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  alu_flags_t nxt,
  output alu_flags_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= nxt;
  end

  // R10: flags stay put on cycles without an update strobe
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(q));

endmodule

// File: rtl/byte_flag_alu.sv
module byte_flag_alu
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   in_op,
  input  logic [W-1:0] in_dst,
  input  logic [W-1:0] in_src,
  input  logic         in_carry,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_wr_en,
  output logic         flag_zero,
  output logic         flag_carry,
  output logic         flag_sign,
  output logic         flag_ovf,
  output logic         flag_parity
);
  localparam int MSB = W - 1;

  // operation decode, named for the assertions
  logic op_known, op_add, op_adc, op_sub, op_sbb, op_cmp;
  logic op_and, op_or, op_xor, op_test, op_not, op_neg;
  logic cls_arith, cls_logic, wants_write, wants_flags;

  always_comb begin
    op_known    = (in_op <= 4'(OP_NEG));
    op_add      = (in_op == OP_ADD);
    op_adc      = (in_op == OP_ADC);
    op_sub      = (in_op == OP_SUB);
    op_sbb      = (in_op == OP_SBB);
    op_cmp      = (in_op == OP_CMP);
    op_and      = (in_op == OP_AND);
    op_or       = (in_op == OP_OR);
    op_xor      = (in_op == OP_XOR);
    op_test     = (in_op == OP_TEST);
    op_not      = (in_op == OP_NOT);
    op_neg      = (in_op == OP_NEG);
    cls_arith   = op_add | op_adc | op_sub | op_sbb | op_cmp | op_neg;
    cls_logic   = op_and | op_or | op_xor | op_test;
    wants_write = op_known & ~op_cmp & ~op_test;
    wants_flags = op_known & ~op_not;
  end

  // adder/subtractor operands
  logic [W-1:0] as_a, as_b, as_res;
  logic         as_cin, as_sub, as_carry, as_ovf;

  always_comb begin
    as_a   = op_neg ? '0 : in_dst;
    as_b   = op_neg ? in_dst : in_src;
    as_cin = (op_adc | op_sbb) & in_carry;
    as_sub = op_sub | op_sbb | op_cmp | op_neg;
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a      (as_a),
    .b      (as_b),
    .cin    (as_cin),
    .do_sub (as_sub),
    .res    (as_res),
    .carry  (as_carry),
    .ovf    (as_ovf)
  );

  logic_sel_e   lg_sel;
  logic [W-1:0] lg_res;

  always_comb begin
    if (op_or)       lg_sel = LG_OR;
    else if (op_xor) lg_sel = LG_XOR;
    else if (op_not) lg_sel = LG_INV;
    else             lg_sel = LG_AND;
  end

  alu8_logic #(.W(W)) u_logic (
    .a   (in_dst),
    .b   (in_src),
    .sel (lg_sel),
    .res (lg_res)
  );

  // result select and next flags
  logic [W-1:0] res_now;
  alu_flags_t   flags_nxt, flags_q;

  always_comb begin
    if (cls_arith)               res_now = as_res;
    else if (cls_logic | op_not) res_now = lg_res;
    else                         res_now = '0;
    flags_nxt.zero   = (res_now == '0);
    flags_nxt.sign   = res_now[MSB];
    flags_nxt.parity = even_ones(res_now[7:0]);
    flags_nxt.carry  = cls_arith & as_carry;
    flags_nxt.ovf    = cls_arith & as_ovf;
  end

  alu8_flagreg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (in_valid & wants_flags),
    .nxt   (flags_nxt),
    .q     (flags_q)
  );

  // markers of what the last strobe did, used by the checks below
  logic upd_q, logic_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_wr_en  <= 1'b0;
      out_result <= '0;
      upd_q      <= 1'b0;
      logic_q    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_wr_en <= in_valid & wants_write;
      upd_q     <= in_valid & wants_flags;
      logic_q   <= in_valid & cls_logic;
      if (in_valid) out_result <= res_now;
    end
  end

  assign flag_zero   = flags_q.zero;
  assign flag_carry  = flags_q.carry;
  assign flag_sign   = flags_q.sign;
  assign flag_ovf    = flags_q.ovf;
  assign flag_parity = flags_q.parity;

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (flag_zero == (out_result == '0)));

  p_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (flag_sign == out_result[MSB]));

  p_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (flag_parity == ~(^out_result[7:0])));

  p_logic_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    logic_q |-> (!flag_carry && !flag_ovf));

  p_not_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_NOT) |=> $stable(flags_q));

  p_probe_nowr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == OP_CMP || in_op == OP_TEST)) |=> !out_wr_en);

  p_wr_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> out_valid);

endmodule

// File: tb/tb_byte_flag_alu.sv
`timescale 1ns/1ps
module tb_byte_flag_alu;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] in_op;
  logic [7:0] in_dst, in_src;
  logic       in_carry;
  logic       out_valid, out_wr_en;
  logic [7:0] out_result;
  logic       flag_zero, flag_carry, flag_sign, flag_ovf, flag_parity;

  always #2.5 clk = ~clk;

  byte_flag_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src(in_src), .in_carry(in_carry),
    .out_valid(out_valid), .out_result(out_result), .out_wr_en(out_wr_en),
    .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_sign(flag_sign),
    .flag_ovf(flag_ovf), .flag_parity(flag_parity)
  );

  int n_tests = 0;
  int n_fail  = 0;
  // bench model of the flag register
  int mz = 0, mc = 0, ms = 0, mo = 0, mp = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  task automatic check_flags(input string rz, input string rc);
    check("R2", "zero",   int'(flag_zero),   mz);
    check("R3", "sign",   int'(flag_sign),   ms);
    check("R4", "parity", int'(flag_parity), mp);
    check(rc,   "carry",  int'(flag_carry),  mc);
    check(rc,   "ovf",    int'(flag_ovf),    mo);
    if (rz != "") check(rz, "zero-hold", int'(flag_zero), mz);
  endtask

  task automatic run_vec(input int op, input int d, input int s, input int c);
    int t, st, res, cc, oo, wr, upd;
    string rc, rw;
    res = 0; cc = 0; oo = 0; wr = 0; upd = 0; rc = "R10"; rw = "R10";
    case (op)
      0, 1: begin
        t  = d + s + ((op == 1) ? c : 0);
        st = sgn(d) + sgn(s) + ((op == 1) ? c : 0);
        res = t & 255; cc = (t > 255); oo = (st > 127 || st < -128);
        wr = 1; upd = 1; rc = "R7"; rw = "R1";
      end
      2, 3, 4: begin
        t  = d - s - ((op == 3) ? c : 0);
        st = sgn(d) - sgn(s) - ((op == 3) ? c : 0);
        res = t & 255; cc = (t < 0); oo = (st > 127 || st < -128);
        wr = (op != 4); upd = 1; rc = "R8"; rw = (op == 4) ? "R9" : "R1";
      end
      10: begin
        t = -d; st = -sgn(d);
        res = t & 255; cc = (t < 0); oo = (st > 127);
        wr = 1; upd = 1; rc = "R8"; rw = "R1";
      end
      5, 8: begin res = d & s; wr = (op == 5); upd = 1; rc = "R5"; rw = (op == 8) ? "R9" : "R1"; end
      6:    begin res = d | s; wr = 1; upd = 1; rc = "R5"; rw = "R1"; end
      7:    begin res = d ^ s; wr = 1; upd = 1; rc = "R5"; rw = "R1"; end
      9:    begin res = (~d) & 255; wr = 1; upd = 0; rc = "R6"; rw = "R1"; end
      default: begin upd = 0; wr = 0; end
    endcase
    if (upd != 0) begin
      mz = (res == 0); ms = (res >> 7) & 1; mp = ((ones(res) % 2) == 0);
      mc = cc; mo = oo;
    end
    in_valid = 1'b1; in_op = 4'(op); in_dst = 8'(d); in_src = 8'(s); in_carry = c[0];
    @(negedge clk);
    check("R1", "valid", int'(out_valid), 1);
    if (op <= 10) check("R1", "result", int'(out_result), res);
    check(rw, "wr_en", int'(out_wr_en), wr);
    check_flags((op == 9) ? "R6" : "", rc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_dst = '0; in_src = '0; in_carry = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11", "valid",  int'(out_valid),  0);
    check("R11", "wr_en",  int'(out_wr_en),  0);
    check("R11", "result", int'(out_result), 0);
    check("R11", "flags",  int'({flag_zero, flag_carry, flag_sign, flag_ovf, flag_parity}), 0);

    // named corners
    run_vec(0, 8'h7F, 1, 0);          // R7 overflow
    check("R7", "ovf 7F+1", int'(flag_ovf), 1);
    run_vec(2, 8'h80, 1, 0);          // R8 overflow
    check("R8", "ovf 80-1", int'(flag_ovf), 1);
    run_vec(10, 8'h80, 0, 0);         // R8 neg 80h
    check("R8", "neg80 res", int'(out_result), 8'h80);
    check("R8", "neg80 ovf", int'(flag_ovf), 1);
    run_vec(10, 8'h7F, 0, 0);         // R8 neg 7Fh
    check("R8", "neg7F res", int'(out_result), 8'h81);
    check("R8", "neg7F ovf", int'(flag_ovf), 0);
    run_vec(4, 5, 10, 0);             // R8 borrow on compare
    check("R8", "cmp carry", int'(flag_carry), 1);
    run_vec(4, 8'hE8, 8'hE8, 0);      // R9 equal compare
    check("R9", "cmp zero", int'(flag_zero), 1);
    run_vec(1, 8'hFF, 8'hFF, 0);      // R7 FF+FF
    check("R7", "adc carry", int'(flag_carry), 1);
    run_vec(9, 8'hF0, 0, 0);          // R6 NOT after carry set
    check("R6", "not res", int'(out_result), 8'h0F);
    check("R6", "not carry kept", int'(flag_carry), 1);
    run_vec(8, 8'h24, 8'h09, 0);      // R9 test all clear
    check("R9", "test zero", int'(flag_zero), 1);

    // strided sweep over all defined codes
    for (int op = 0; op < 11; op++)
      for (int d = 0; d < 256; d += 5)
        for (int s = 0; s < 256; s += 7)
          for (int c = 0; c < 2; c++)
            run_vec(op, d, s, c);
    // exhaustive negate and inversion
    for (int d = 0; d < 256; d++) begin
      run_vec(10, d, 0, 0);
      run_vec(9, d, 0, 1);
    end
    // R10: unassigned codes
    run_vec(2, 3, 7, 0);
    for (int op = 11; op < 16; op++) run_vec(op, 8'h00, 8'h00, 1);
    // R10: idle cycles with misleading inputs
    in_valid = 1'b0; in_op = 4'd0; in_dst = 8'h00; in_src = 8'h00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10", "idle valid", int'(out_valid), 0);
      check("R10", "idle wr_en", int'(out_wr_en), 0);
      check_flags("R10", "R10");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule